// File: doc/BRIEF.md
# Per-Module Message Buffer Forwarder

This block parks messages addressed to function modules that are not currently loaded and releases them once those modules are resident again. All modules share one storage pool of message elements. Each module's buffer is a singly linked list threaded through that pool. Unused elements sit on a free list. Storing a message unlinks an element from the free list and appends it to the module's list. Releasing a message moves the head element back to the free list. Only pointers change; no payload is ever copied.

A round-robin scanner walks the module buffers in ascending index order and spends at least one cycle on each. When the buffer under the scanner is non-empty and its module is flagged active, the head message is offered on a valid/ready output. The scanner stays on that buffer until the offer is taken or the module stops being active, and then moves on. This means a module receives at most one message per pass of the scanner. The gap gives the module time to settle before its next message.

Top module: `msgbuf_fwd`

## Requirements
- R1: After reset every buffer reports empty (all `empty_o` bits 1), `out_valid_o` is 0 and `ovf_o` is 0.
- R2: Messages stored for one module leave in the order they were stored.
- R3: Two transfers to the same module are at least NUM_Q (8) clock edges apart, so each module gets at most one message per scanner pass.
- R4: Within a pass, modules are served in ascending index order. With modules 1, 5 and 6 eligible, consecutive transfers follow the cycle 1, 5, 6, 1, ...
- R5: A buffer whose `active_i` bit is 0 is never offered, and its contents and `empty_o` bit stay as they are. Once the bit is set, the buffer is drained in order.
- R6: The pool holds DEPTH (32) messages in total across all buffers. A store attempted while all 32 are occupied is refused and does not appear at the output. `ovf_o` is 1 for exactly the one cycle after the refused store edge.
- R7: Released elements return to the free list. After the pool has been filled and drained, another 32 stores are accepted without overflow.
- R8: `empty_o[m]` is 0 from the edge that stores a message for module m. It returns to 1 at the edge that transfers that module's last message.
- R9: While an offer is pending with `out_ready_i` low, `out_qid_o` and `out_data_o` hold steady. If the module's `active_i` bit falls, `out_valid_o` drops at once and the message stays buffered.
- R10: A store and a transfer for the same module in the same cycle keep both the message count and the order correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid_i | input | 1 | Store request, one message per cycle |
| enq_qid_i | input | 3 | Destination module index of the stored message |
| enq_data_i | input | 32 | Message payload |
| ovf_o | output | 1 | Pulses for one cycle after a store refused because the pool is full |
| active_i | input | 8 | One bit per module: 1 = module resident and able to receive |
| out_valid_o | output | 1 | Head message offered |
| out_ready_i | input | 1 | Receiver accepts the offered message |
| out_qid_o | output | 3 | Module index of the offered message |
| out_data_o | output | 32 | Payload of the offered message |
| empty_o | output | 8 | One bit per module: 1 = buffer empty |

## Verification
The bench fills the pool to exactly 32 entries over all eight buffers and then tries one more store. A design with an off-by-one free count would either refuse the 32nd message or accept the 33rd, and the extra message would show up at the output. It then drains the pool and refills it. A free list that loses elements on release would raise overflow early on the second fill. A steady stream of stores into a buffer that is draining at the same time exercises the same-cycle store and release path. A tail-pointer bug there breaks order or drops messages. The bench also checks the cycle order of transfers among several eligible modules and the spacing between them. A scanner that sends a whole buffer at once, or skips ahead, breaks both. It stalls and then withdraws an offer by clearing the module's active bit, which catches a design that releases a message that was never accepted.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

    localparam int unsigned MB_NUM_Q  = 8;
    localparam int unsigned MB_DEPTH  = 32;
    localparam int unsigned MB_DATA_W = 32;

    // Next index of a ring of n positions.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/msgbuf_pool.sv
module msgbuf_pool #(
    parameter int unsigned NUM_Q  = msgbuf_pkg::MB_NUM_Q,
    parameter int unsigned DEPTH  = msgbuf_pkg::MB_DEPTH,
    parameter int unsigned DATA_W = msgbuf_pkg::MB_DATA_W,
    localparam int unsigned QID_W = $clog2(NUM_Q),
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid_i,
    input  logic [QID_W-1:0]  enq_qid_i,
    input  logic [DATA_W-1:0] enq_data_i,
    input  logic              deq_valid_i,
    input  logic [QID_W-1:0]  deq_qid_i,
    input  logic [QID_W-1:0]  rd_qid_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NUM_Q-1:0]  empty_o,
    output logic              full_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PTR_W-1:0]  nxt;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [NUM_Q-1:0][PTR_W-1:0]  head;
        logic [NUM_Q-1:0][PTR_W-1:0]  tail;
        logic [NUM_Q-1:0][CNT_W-1:0]  cnt;
        logic [PTR_W-1:0]             free_head;
        logic [CNT_W-1:0]             free_cnt;
        logic                         ovf;
    } pool_state_t;

    pool_state_t st_d, st_q;
    logic [PTR_W-1:0] rel_ptr;
    logic [PTR_W-1:0] take_ptr;
    logic             enq_ok;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        rel_ptr  = st_q.head[deq_qid_i];
        take_ptr = '0;
        // Refusal depends only on occupancy at the start of the cycle.
        enq_ok   = enq_valid_i && (st_q.free_cnt != '0);

        // Release first: head element of the served list goes to the free list.
        if (deq_valid_i) begin
            st_d.head[deq_qid_i] = st_q.nxt[rel_ptr];
            st_d.cnt[deq_qid_i]  = st_q.cnt[deq_qid_i] - CNT_W'(1);
            st_d.nxt[rel_ptr]    = st_q.free_head;
            st_d.free_head       = rel_ptr;
            st_d.free_cnt        = st_q.free_cnt + CNT_W'(1);
        end

        // Then store, working on the state left by the release.
        if (enq_ok) begin
            take_ptr           = st_d.free_head;
            st_d.free_head     = st_d.nxt[take_ptr];
            st_d.free_cnt      = st_d.free_cnt - CNT_W'(1);
            st_d.mem[take_ptr] = enq_data_i;
            if (st_d.cnt[enq_qid_i] == '0) begin
                st_d.head[enq_qid_i] = take_ptr;
            end else begin
                st_d.nxt[st_d.tail[enq_qid_i]] = take_ptr;
            end
            st_d.tail[enq_qid_i] = take_ptr;
            st_d.cnt[enq_qid_i]  = st_d.cnt[enq_qid_i] + CNT_W'(1);
        end else if (enq_valid_i) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                st_q.nxt[i] <= PTR_W'(i + 1);
            end
            st_q.free_cnt <= CNT_W'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < int'(NUM_Q); g++) begin : g_empty
        assign empty_o[g] = (st_q.cnt[g] == '0);
    end

    assign rd_data_o = st_q.mem[st_q.head[rd_qid_i]];
    assign full_o    = (st_q.free_cnt == '0);
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/msgbuf_scan.sv
module msgbuf_scan #(
    parameter int unsigned NUM_Q = msgbuf_pkg::MB_NUM_Q,
    localparam int unsigned QID_W = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] active_i,
    input  logic [NUM_Q-1:0] empty_i,
    input  logic             out_ready_i,
    output logic             out_valid_o,
    output logic [QID_W-1:0] idx_o,
    output logic             deq_o
);

    typedef struct packed {
        logic [QID_W-1:0] idx;
    } scan_state_t;

    scan_state_t sc_d, sc_q;
    logic        eligible;

    always_comb begin
        sc_d     = sc_q;
        eligible = active_i[sc_q.idx] && !empty_i[sc_q.idx];
        // Hold on an offer until it is taken; otherwise step to the next module.
        if (!eligible || out_ready_i) begin
            sc_d.idx = QID_W'(msgbuf_pkg::ring_next(int'(sc_q.idx), NUM_Q));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign out_valid_o = eligible;
    assign idx_o       = sc_q.idx;
    assign deq_o       = eligible && out_ready_i;

endmodule

// File: rtl/msgbuf_fwd.sv
module msgbuf_fwd #(
    parameter int unsigned NUM_Q  = msgbuf_pkg::MB_NUM_Q,
    parameter int unsigned DEPTH  = msgbuf_pkg::MB_DEPTH,
    parameter int unsigned DATA_W = msgbuf_pkg::MB_DATA_W,
    localparam int unsigned QID_W = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid_i,
    input  logic [QID_W-1:0]  enq_qid_i,
    input  logic [DATA_W-1:0] enq_data_i,
    output logic              ovf_o,
    input  logic [NUM_Q-1:0]  active_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [QID_W-1:0]  out_qid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic [NUM_Q-1:0]  empty_o
);

    logic             pool_full;
    logic             deq_valid;
    logic [QID_W-1:0] scan_idx;

    msgbuf_pool #(
        .NUM_Q (NUM_Q),
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid_i(enq_valid_i),
        .enq_qid_i  (enq_qid_i),
        .enq_data_i (enq_data_i),
        .deq_valid_i(deq_valid),
        .deq_qid_i  (scan_idx),
        .rd_qid_i   (scan_idx),
        .rd_data_o  (out_data_o),
        .empty_o    (empty_o),
        .full_o     (pool_full),
        .ovf_o      (ovf_o)
    );

    msgbuf_scan #(
        .NUM_Q(NUM_Q)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active_i),
        .empty_i    (empty_o),
        .out_ready_i(out_ready_i),
        .out_valid_o(out_valid_o),
        .idx_o      (scan_idx),
        .deq_o      (deq_valid)
    );

    assign out_qid_o = scan_idx;

endmodule

// File: rtl/msgbuf_fwd_chk.sv
module msgbuf_fwd_chk #(
    parameter int unsigned NUM_Q  = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned QID_W = $clog2(NUM_Q),
    localparam int unsigned GAP_W = $clog2(NUM_Q + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_valid_i,
    input logic [QID_W-1:0]  enq_qid_i,
    input logic              ovf_o,
    input logic              pool_full,
    input logic [NUM_Q-1:0]  active_i,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [QID_W-1:0]  out_qid_o,
    input logic [DATA_W-1:0] out_data_o,
    input logic [NUM_Q-1:0]  empty_o
);

    // Edges since the last transfer to each module, saturating at NUM_Q.
    logic [NUM_Q-1:0][GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_Q); i++) gap_q[i] <= GAP_W'(NUM_Q);
        end else begin
            for (int i = 0; i < int'(NUM_Q); i++) begin
                if (out_valid_o && out_ready_i && (int'(out_qid_o) == i)) begin
                    gap_q[i] <= GAP_W'(1);
                end else if (gap_q[i] < GAP_W'(NUM_Q)) begin
                    gap_q[i] <= gap_q[i] + GAP_W'(1);
                end
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (&empty_o && !out_valid_o && !ovf_o)); // R1

    AST_ROUND_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |-> (gap_q[out_qid_o] >= GAP_W'(NUM_Q))); // R3

    AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (active_i[out_qid_o] && !empty_o[out_qid_o])); // R5

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(enq_valid_i && pool_full)); // R6

    AST_NOT_EMPTY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid_i && !pool_full) |=> !empty_o[$past(enq_qid_i)]); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (!out_valid_o || (out_qid_o == $past(out_qid_o) && out_data_o == $past(out_data_o)))); // R9

endmodule

bind msgbuf_fwd msgbuf_fwd_chk #(
    .NUM_Q (NUM_Q),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid_i(enq_valid_i),
    .enq_qid_i  (enq_qid_i),
    .ovf_o      (ovf_o),
    .pool_full  (pool_full),
    .active_i   (active_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_qid_o  (out_qid_o),
    .out_data_o (out_data_o),
    .empty_o    (empty_o)
);

// File: tb/msgbuf_fwd_bench.sv
`timescale 1ns/1ps
module msgbuf_fwd_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [2:0]  enq_qid = '0;
    logic [31:0] enq_data = '0;
    logic        ovf;
    logic [7:0]  active = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_qid;
    logic [31:0] out_data;
    logic [7:0]  empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int          log_n = 0;
    logic [2:0]  log_qid [256];
    logic [31:0] log_data[256];
    int          log_cyc [256];

    always #2.5 clk = ~clk;

    msgbuf_fwd u_msgbuf_fwd (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid_i(enq_valid),
        .enq_qid_i  (enq_qid),
        .enq_data_i (enq_data),
        .ovf_o      (ovf),
        .active_i   (active),
        .out_valid_o(out_valid),
        .out_ready_i(out_ready),
        .out_qid_o  (out_qid),
        .out_data_o (out_data),
        .empty_o    (empty)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Record each transfer that the next rising edge will complete.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && log_n < 256) begin
            log_qid[log_n]  = out_qid;
            log_data[log_n] = out_data;
            log_cyc[log_n]  = cyc;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end one time unit after a rising edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic enq(input int q, input logic [31:0] d);
        enq_valid = 1'b1;
        enq_qid   = 3'(q);
        enq_data  = d;
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(empty == 8'hFF, "R1 empty", 64'(empty), 64'hFF);
        chk(!out_valid, "R1 valid", 64'(out_valid), 0);
        chk(!ovf, "R1 ovf", 64'(ovf), 0);
    endtask

    task automatic t_order;
        active = '0; out_ready = 1'b1;
        for (int i = 0; i < 3; i++) enq(2, 32'hA000_0000 + 32'(i));
        chk(!empty[2], "R8 not empty after store", 64'(empty[2]), 0);
        step(4);
        chk(!out_valid, "R5 inactive not offered", 64'(out_valid), 0);
        log_n = 0;
        active[2] = 1'b1;
        step(30);
        chk(log_n == 3, "R2 count", 64'(log_n), 3);
        for (int i = 0; i < 3; i++)
            chk(log_qid[i] == 3'd2 && log_data[i] == 32'hA000_0000 + 32'(i), "R2 order",
                64'(log_data[i]), 64'(32'hA000_0000 + 32'(i)));
        chk(empty[2], "R8 empty after drain", 64'(empty[2]), 1);
        active = '0;
    endtask

    function automatic int succ156(input int q);
        return (q == 1) ? 5 : (q == 5) ? 6 : 1;
    endfunction

    task automatic t_scan;
        active = '0; out_ready = 1'b1;
        for (int k = 0; k < 2; k++) begin
            enq(1, 32'hB100_0000 + 32'(k));
            enq(5, 32'hB500_0000 + 32'(k));
            enq(6, 32'hB600_0000 + 32'(k));
        end
        enq(3, 32'hB300_0000);
        log_n = 0;
        active = 8'b0110_0010;
        step(40);
        chk(log_n == 6, "R3 two per module", 64'(log_n), 6);
        for (int k = 1; k < 6; k++)
            chk(int'(log_qid[k]) == succ156(int'(log_qid[k-1])), "R4 ascending cycle",
                64'(log_qid[k]), 64'(succ156(int'(log_qid[k-1]))));
        for (int k = 3; k < 6; k++) begin
            chk(log_qid[k] == log_qid[k-3] && log_cyc[k] - log_cyc[k-3] >= 8, "R3 spacing",
                64'(log_cyc[k] - log_cyc[k-3]), 8);
            chk(log_data[k] == log_data[k-3] + 32'd1, "R2 per module order",
                64'(log_data[k]), 64'(log_data[k-3] + 32'd1));
        end
        chk(!empty[3], "R5 inactive buffer kept", 64'(empty[3]), 0);
        active[3] = 1'b1;
        step(20);
        chk(log_n == 7 && log_qid[6] == 3'd3 && log_data[6] == 32'hB300_0000, "R5 drained on activation",
            64'(log_data[6]), 64'hB300_0000);
        active = '0;
    endtask

    task automatic t_stall;
        active = '0; out_ready = 1'b0;
        active[4] = 1'b1;
        enq(4, 32'hC400_0000);
        step(10);
        chk(out_valid && out_qid == 3'd4 && out_data == 32'hC400_0000, "R9 offer", 64'(out_data), 64'hC400_0000);
        step(3);
        chk(out_valid && out_qid == 3'd4 && out_data == 32'hC400_0000, "R9 hold", 64'(out_data), 64'hC400_0000);
        log_n = 0;
        out_ready = 1'b1;
        step(12);
        chk(log_n == 1 && empty[4], "R9 single transfer", 64'(log_n), 1);
        out_ready = 1'b0;
        enq(4, 32'hC400_0001);
        step(10);
        chk(out_valid, "R9 second offer", 64'(out_valid), 1);
        active[4] = 1'b0;
        #1;
        chk(!out_valid, "R9 withdraw", 64'(out_valid), 0);
        step(3);
        chk(!empty[4] && !out_valid, "R5 kept after withdraw", 64'(empty[4]), 0);
        log_n = 0;
        active[4] = 1'b1; out_ready = 1'b1;
        step(12);
        chk(log_n == 1 && log_data[0] == 32'hC400_0001, "R9 withdrawn message kept", 64'(log_data[0]), 64'hC400_0001);
        active = '0;
    endtask

    task automatic fill_and_drain(input logic [31:0] base, input string tag);
        int ovf_seen;
        int k_seen[8];
        active = '0; out_ready = 1'b0;
        ovf_seen = 0;
        for (int i = 0; i < 32; i++) begin
            enq(i % 8, base + 32'(i));
            if (ovf) ovf_seen++;
        end
        chk(ovf_seen == 0, {tag, " no ovf within capacity"}, 64'(ovf_seen), 0);
        chk(empty == 8'h00, {tag, " all buffers hold data"}, 64'(empty), 0);
        if (tag == "R6") begin
            enq(0, 32'hDEAD_BEEF);
            chk(ovf, "R6 ovf on 33rd store", 64'(ovf), 1);
            step(1);
            chk(!ovf, "R6 ovf one cycle", 64'(ovf), 0);
        end
        log_n = 0;
        active = 8'hFF; out_ready = 1'b1;
        step(80);
        chk(log_n == 32, {tag, " all delivered"}, 64'(log_n), 32);
        for (int q = 0; q < 8; q++) k_seen[q] = 0;
        for (int i = 0; i < log_n; i++) begin
            automatic int q = int'(log_qid[i]);
            automatic logic [31:0] exp = base + 32'(q + 8 * k_seen[q]);
            chk(log_data[i] == exp, "R2 order after fill", 64'(log_data[i]), 64'(exp));
            k_seen[q]++;
        end
        chk(empty == 8'hFF, {tag, " empty after drain"}, 64'(empty), 64'hFF);
        active = '0;
    endtask

    task automatic t_capacity;
        fill_and_drain(32'hD000_0000, "R6");
        fill_and_drain(32'hE000_0000, "R7");
    endtask

    task automatic t_simul;
        int ovf_seen;
        ovf_seen = 0;
        active = '0; out_ready = 1'b1;
        log_n = 0;
        active[7] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            enq(7, 32'hF700_0000 + 32'(i));
            if (ovf) ovf_seen++;
        end
        step(200);
        chk(ovf_seen == 0, "R10 no ovf", 64'(ovf_seen), 0);
        chk(log_n == 20, "R10 count", 64'(log_n), 20);
        for (int i = 0; i < 20; i++)
            chk(log_qid[i] == 3'd7 && log_data[i] == 32'hF700_0000 + 32'(i), "R10 order",
                64'(log_data[i]), 64'(32'hF700_0000 + 32'(i)));
        for (int i = 1; i < 20; i++)
            chk(log_cyc[i] - log_cyc[i-1] >= 8, "R3 spacing under stream", 64'(log_cyc[i] - log_cyc[i-1]), 8);
        chk(empty[7], "R10 empty at end", 64'(empty[7]), 1);
        active = '0;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_order();
        t_scan();
        t_stall();
        t_capacity();
        t_simul();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule